// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This unit turns one 6-bit operand specifier into either a register operand or a 16-bit memory address. It owns a file of eight 16-bit general registers, and the last of them (index 7) serves as the program counter. The unit handles automatic stepping of a pointer register before or after its use. It also fetches an index word from the instruction stream and follows one level of indirection through memory. A surrounding instruction sequencer loads the registers, pulses `start` with a specifier and a byte/word flag, and waits for `done`.

The unit does not treat the program counter as a special case, so the usual instruction-stream forms fall out of the general modes. A post-stepped read through the counter fetches an immediate word. A deferred post-stepped read through the counter fetches an absolute address. The indexed modes through the counter give PC-relative addressing, because the counter has already moved past the index word when the sum is formed. Memory reads use a request/valid handshake of any latency.

Top module: `opnd_ea_unit`

## Requirements
- R1: The specifier carries the mode in bits 5:3 and the register index in bits 2:0. Mode 0 yields `is_reg`=1 with `ea` equal to the register index zero-extended, and changes no register.
- R2: Mode 1 yields `ea` equal to the selected register, with `is_reg`=0 and no register change.
- R3: Mode 2 yields `ea` equal to the register's old value, and then advances the register by 2 for a word operation (`byte_op`=0) or by 1 for a byte operation.
- R4: Mode 3 reads memory at the register's old value and returns the word read as `ea`. The register always advances by 2.
- R5: Mode 4 first lowers the register by 2 for a word or by 1 for a byte. It then yields the new value as `ea`.
- R6: Mode 5 always lowers the register by 2 first, then reads memory at the new value and returns the word read as `ea`.
- R7: Mode 6 reads an index word at the current value of register 7 and raises register 7 by 2. It then yields `ea` = index + selected register, taking the selected register after that increment and wrapping modulo 2^16.
- R8: Mode 7 forms the same sum as mode 6, then reads memory at the sum and returns the word read as `ea`.
- R9: Register 7 steps by 2 in modes 2 and 4 even when `byte_op`=1.
- R10: `mem_req` is high only while a read is pending. It holds `mem_addr` stable until a cycle with `mem_valid`, and it is low whenever `done` is high.
- R11: `done` is high for exactly one cycle per accepted `start`, after every register update is visible on the read port. `ea` and `is_reg` hold their values until the next start. A `start` during a busy operation is ignored.
- R12: After reset all registers read 0, and `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `spec` (taken only when idle) |
| spec | input | 6 | Operand specifier: mode in 5:3, register in 2:0 |
| byte_op | input | 1 | 1 for a byte operand, 0 for a word operand |
| rf_we | input | 1 | Register load strobe from the sequencer |
| rf_sel | input | 3 | Register index for the load |
| rf_wdata | input | 16 | Register load value |
| rd_sel | input | 3 | Register index for the read port |
| rd_data | output | 16 | Current value of register `rd_sel` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data |
| mem_valid | input | 1 | Read data valid, completes the request |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | 1 when the operand is a register |
| ea | output | 16 | Resolved address, or the register index in mode 0 |

## Verification
The hardest case to reach is the interplay in the program-counter-relative modes. There, the register that is summed is the same counter that was just bumped, and the deferred variant then needs a second read whose address comes from that sum. The bench sweeps all 64 specifiers in both byte and word form, with memory latencies of 0 to 2 cycles, over general register values and over values of 0 and all-ones that force wraparound. A directed case raises `start` again, with a different specifier, while a deferred read is still waiting.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned REG_N  = 8;
    localparam int unsigned IDX_W  = $clog2(REG_N);
    localparam int unsigned SPEC_W = 6;
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(REG_N - 1);

    typedef enum logic [2:0] {
        AM_REG    = 3'd0,
        AM_DEF    = 3'd1,
        AM_INC    = 3'd2,
        AM_INCDEF = 3'd3,
        AM_DEC    = 3'd4,
        AM_DECDEF = 3'd5,
        AM_IDX    = 3'd6,
        AM_IDXDEF = 3'd7
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_INDEX,
        ST_PTR,
        ST_DONE
    } ea_state_e;

    typedef struct packed {
        amode_e           mode;
        logic [IDX_W-1:0] rn;
        logic             byte_op;
    } ea_req_t;

    function automatic ea_req_t unpack_spec(logic [SPEC_W-1:0] s, logic b);
        ea_req_t r;
        r.mode    = amode_e'(s[5:3]);
        r.rn      = s[2:0];
        r.byte_op = b;
        return r;
    endfunction

    // Deferred step modes and the program counter always move by a full word.
    function automatic logic full_step(ea_req_t r);
        return (r.mode == AM_INCDEF) || (r.mode == AM_DECDEF) ||
               !r.byte_op || (r.rn == PC_IDX);
    endfunction

endpackage

// File: rtl/opnd_ea_step.sv
module opnd_ea_step
    import opnd_ea_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  ea_req_t       req,
    output logic [DW-1:0] delta
);
    localparam logic [DW-1:0] WORD_STEP = DW'(2);
    localparam logic [DW-1:0] BYTE_STEP = DW'(1);

    always_comb delta = full_step(req) ? WORD_STEP : BYTE_STEP;
endmodule

// File: rtl/opnd_ea_regfile.sv
module opnd_ea_regfile
    import opnd_ea_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned N  = REG_N,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_sel,
    input  logic [DW-1:0] ext_wdata,
    input  logic          int_we,
    input  logic [IW-1:0] int_sel,
    input  logic [DW-1:0] int_wdata,
    input  logic [IW-1:0] ra_sel,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_sel,
    output logic [DW-1:0] rb_data,
    input  logic [IW-1:0] rc_sel,
    output logic [DW-1:0] rc_data
);
    logic [DW-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (int_we && int_sel == IW'(g))
                regs[g] <= int_wdata;
            else if (ext_we && ext_sel == IW'(g))
                regs[g] <= ext_wdata;
        end
    end

    always_comb begin
        ra_data = regs[ra_sel];
        rb_data = regs[rb_sel];
        rc_data = regs[rc_sel];
    end
endmodule

// File: rtl/opnd_ea_ctrl.sv
module opnd_ea_ctrl
    import opnd_ea_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SPEC_W-1:0] spec,
    input  logic              byte_op,
    output ea_req_t           req_q,
    input  logic [DW-1:0]     delta,
    input  logic [DW-1:0]     reg_q,
    input  logic [DW-1:0]     pc_q,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DW-1:0]     wr_data,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_valid,
    output logic              done,
    output logic              is_reg,
    output logic [DW-1:0]     ea
);
    localparam logic [DW-1:0] PC_STEP = DW'(2);

    ea_state_e     st;
    logic [DW-1:0] addr_q, ea_q;
    logic          isreg_q;
    logic [DW-1:0] idx_sum;

    always_comb idx_sum = mem_rdata + reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            req_q   <= '0;
            addr_q  <= '0;
            ea_q    <= '0;
            isreg_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    req_q <= unpack_spec(spec, byte_op);
                    st    <= ST_EXEC;
                end
                ST_EXEC: begin
                    isreg_q <= 1'b0;
                    unique case (req_q.mode)
                        AM_REG: begin
                            isreg_q <= 1'b1;
                            ea_q    <= DW'(req_q.rn);
                            st      <= ST_DONE;
                        end
                        AM_DEF, AM_INC: begin
                            ea_q <= reg_q;
                            st   <= ST_DONE;
                        end
                        AM_INCDEF: begin
                            addr_q <= reg_q;
                            st     <= ST_PTR;
                        end
                        AM_DEC: begin
                            ea_q <= reg_q - delta;
                            st   <= ST_DONE;
                        end
                        AM_DECDEF: begin
                            addr_q <= reg_q - delta;
                            st     <= ST_PTR;
                        end
                        default: begin
                            addr_q <= pc_q;
                            st     <= ST_INDEX;
                        end
                    endcase
                end
                ST_INDEX: if (mem_valid) begin
                    if (req_q.mode == AM_IDX) begin
                        ea_q <= idx_sum;
                        st   <= ST_DONE;
                    end else begin
                        addr_q <= idx_sum;
                        st     <= ST_PTR;
                    end
                end
                ST_PTR: if (mem_valid) begin
                    ea_q <= mem_rdata;
                    st   <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = req_q.rn;
        wr_data = reg_q;
        if (st == ST_EXEC) begin
            unique case (req_q.mode)
                AM_INC, AM_INCDEF: begin
                    wr_en   = 1'b1;
                    wr_data = reg_q + delta;
                end
                AM_DEC, AM_DECDEF: begin
                    wr_en   = 1'b1;
                    wr_data = reg_q - delta;
                end
                AM_IDX, AM_IDXDEF: begin
                    wr_en   = 1'b1;
                    wr_idx  = PC_IDX;
                    wr_data = pc_q + PC_STEP;
                end
                default: wr_en = 1'b0;
            endcase
        end
    end

    always_comb begin
        mem_req  = (st == ST_INDEX) || (st == ST_PTR);
        mem_addr = addr_q;
        done     = (st == ST_DONE);
        is_reg   = isreg_q;
        ea       = ea_q;
    end
endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit
    import opnd_ea_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SPEC_W-1:0] spec,
    input  logic              byte_op,
    input  logic              rf_we,
    input  logic [IDX_W-1:0]  rf_sel,
    input  logic [DW-1:0]     rf_wdata,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [DW-1:0]     rd_data,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_valid,
    output logic              done,
    output logic              is_reg,
    output logic [DW-1:0]     ea
);
    ea_req_t          req_q;
    logic [DW-1:0]    delta, reg_q, pc_q, wr_data;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    opnd_ea_step #(.DW(DW)) u_step (
        .req   (req_q),
        .delta (delta)
    );

    opnd_ea_regfile #(.DW(DW), .N(REG_N)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .ext_we    (rf_we),
        .ext_sel   (rf_sel),
        .ext_wdata (rf_wdata),
        .int_we    (wr_en),
        .int_sel   (wr_idx),
        .int_wdata (wr_data),
        .ra_sel    (req_q.rn),
        .ra_data   (reg_q),
        .rb_sel    (PC_IDX),
        .rb_data   (pc_q),
        .rc_sel    (rd_sel),
        .rc_data   (rd_data)
    );

    opnd_ea_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .spec      (spec),
        .byte_op   (byte_op),
        .req_q     (req_q),
        .delta     (delta),
        .reg_q     (reg_q),
        .pc_q      (pc_q),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_valid (mem_valid),
        .done      (done),
        .is_reg    (is_reg),
        .ea        (ea)
    );
endmodule

// File: rtl/opnd_ea_chk.sv
module opnd_ea_chk
    import opnd_ea_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [SPEC_W-1:0] spec,
    input logic              byte_op,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_sel,
    input logic [DW-1:0]     rf_wdata,
    input logic [IDX_W-1:0]  rd_sel,
    input logic [DW-1:0]     rd_data,
    input logic              mem_req,
    input logic [DW-1:0]     mem_addr,
    input logic [DW-1:0]     mem_rdata,
    input logic              mem_valid,
    input logic              done,
    input logic              is_reg,
    input logic [DW-1:0]     ea
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R10
    req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(ea) && $stable(is_reg)));

    // R1
    reg_index_chk: assert property (@(posedge clk) disable iff (rst)
        (done && is_reg) |-> (ea[DW-1:IDX_W] == '0));
endmodule

bind opnd_ea_unit opnd_ea_chk #(.DW(DW)) u_chk (.*);

// File: tb/opnd_ea_unit_test.sv
`timescale 1ns/1ps
module opnd_ea_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  spec = '0;
    logic        byte_op = 1'b0;
    logic        rf_we = 1'b0;
    logic [2:0]  rf_sel = '0;
    logic [15:0] rf_wdata = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        mem_valid = 1'b0;
    logic        done, is_reg;
    logic [15:0] ea;

    int tests = 0;
    int fails = 0;
    int lat = 0;
    int wait_cnt = 0;
    bit finished = 0;
    logic [15:0] mdl [8];

    always #2 clk = ~clk;

    opnd_ea_unit uut (.*);

    function automatic logic [15:0] memf(logic [15:0] a);
        return a * 16'h9E37 + 16'h1234;
    endfunction

    // memory model: answers each request after lat cycles
    always @(negedge clk) begin
        if (mem_valid) begin
            mem_valid <= 1'b0;
            wait_cnt  <= 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= memf(mem_addr);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_regs(int seed, int kind);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] v;
            if (kind == 1) v = 16'h0000;
            else if (kind == 2) v = 16'hFFFF;
            else v = 16'(seed * 16'h0135 + i * 16'h2223 + 16'h0400);
            @(negedge clk);
            rf_we = 1'b1; rf_sel = 3'(i); rf_wdata = v;
            mdl[i] = v;
        end
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic run_one(logic [5:0] s, logic b, bit hold);
        logic [2:0]  m = s[5:3];
        logic [2:0]  rn = s[2:0];
        logic [15:0] st = (b && rn != 3'd7) ? 16'd1 : 16'd2;
        logic [15:0] exp_ea;
        logic        exp_reg = 1'b0;
        logic [15:0] idx;
        string       tag;
        bit          got = 0;
        case (m)
            3'd0: begin exp_reg = 1'b1; exp_ea = {13'd0, rn}; tag = "R1"; end
            3'd1: begin exp_ea = mdl[rn]; tag = "R2"; end
            3'd2: begin exp_ea = mdl[rn]; mdl[rn] = mdl[rn] + st;
                        tag = (rn == 3'd7 && b) ? "R9" : "R3"; end
            3'd3: begin exp_ea = memf(mdl[rn]); mdl[rn] = mdl[rn] + 16'd2; tag = "R4"; end
            3'd4: begin mdl[rn] = mdl[rn] - st; exp_ea = mdl[rn];
                        tag = (rn == 3'd7 && b) ? "R9" : "R5"; end
            3'd5: begin mdl[rn] = mdl[rn] - 16'd2; exp_ea = memf(mdl[rn]); tag = "R6"; end
            3'd6: begin idx = memf(mdl[7]); mdl[7] = mdl[7] + 16'd2;
                        exp_ea = idx + mdl[rn]; tag = "R7"; end
            default: begin idx = memf(mdl[7]); mdl[7] = mdl[7] + 16'd2;
                        exp_ea = memf(idx + mdl[rn]); tag = "R8"; end
        endcase
        @(negedge clk);
        spec = s; byte_op = b; start = 1'b1;
        for (int c = 0; c < 60 && !got; c++) begin
            @(negedge clk);
            if (done) got = 1;
            start = hold && c < 2;
            if (hold) spec = 6'o20;
        end
        start = 1'b0;
        if (!got) begin
            tests++; fails++;
            $display("FAIL R11: no done, actual 0 expected 1");
            return;
        end
        check(tag, ea, exp_ea);
        check(tag, {15'd0, is_reg}, {15'd0, exp_reg});
        @(negedge clk);
        check("R11", {15'd0, done}, 16'd0);
        check("R10", {15'd0, mem_req}, 16'd0);
        check("R11", ea, exp_ea);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.5;
            check(hold ? "R11" : tag, rd_data, mdl[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        check("R12", {15'd0, done}, 16'd0);
        check("R12", {15'd0, mem_req}, 16'd0);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.5;
            check("R12", rd_data, 16'd0);
        end
        for (int pass = 0; pass < 3; pass++) begin
            for (int t = 0; t < 128; t++) begin
                lat = (t + pass) % 3;
                load_regs(t, pass);
                run_one(6'(t >> 1), t[0], 1'b0);
            end
        end
        // R11: start raised again while a deferred read is pending
        lat = 2;
        load_regs(7, 0);
        run_one(6'o33, 1'b0, 1'b1);
        load_regs(9, 0);
        run_one(6'o75, 1'b1, 1'b1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule